// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed RISC-V instruction (RV32, integer subset) into the full 32-bit base-ISA word that an ordinary decoder already understands. A fetch stage places the halfword on the input with a strobe. The expander returns the equivalent 32-bit encoding, a flag for illegal or reserved encodings, and a flag that tells the consumer the original was 16 bits wide. The consumer needs that last flag because a compressed jump-and-link stores the PC plus 2, and the next sequential PC also advances by 2.

Decoding is done per quadrant, selected by bits 1:0. Quadrant 1 uses nested sub-decodes: bits 11:10 choose the operation, and bits 6:5 choose a register-register operation within that group. Quadrant 2 separates jump, move, breakpoint, jump-and-link and add by bit 12 and by zero tests on the register fields. In quadrant 1, funct3 = 011 is shared between the stack-pointer adjust and load-upper-immediate; the destination field tells them apart.

The result passes through an output register, which is present by default. The register loads only when the input strobe is high, so the last result stays on the outputs while the input is idle.

Top module: `rvc_expander`

## Requirements
- R1: Quadrant 0 (bits 1:0 = 00) expands funct3 000 to `addi rd', x2, uimm`, funct3 010 to `lw rd', uimm(rs1')` and funct3 110 to `sw rs2', uimm(rs1')`. The 3-bit fields in bits 9:7 and 4:2 name registers x8 to x15 (field value + 8). The word offset is zero-extended. Every legal output word ends in bits 1:0 = 11.
- R2: In quadrant 1, funct3 000, 010, 001, 101, 110 and 111 expand as follows:
  - 000 gives `addi rd, rd, simm6`.
  - 010 gives `addi rd, x0, simm6`.
  - 001 gives `jal x1, off`.
  - 101 gives `jal x0, off`.
  - 110 gives `beq rs1', x0, off`.
  - 111 gives `bne rs1', x0, off`.
  
  All immediates are sign-extended.
- R3: In quadrant 1 with funct3 100, bits 11:10 select the operation on rs1':
  - 00 is srli.
  - 01 is srai.
  - 10 is andi with a sign-extended immediate.
  - 11 is a register-register operation on rs1' and rs2' with the result in rs1'. Bits 6:5 then select sub (00), xor (01), or (10) or and (11).
- R4: In quadrant 1 with funct3 011, a destination field of 2 gives `addi x2, x2, imm`, where the immediate is a multiple of 16 and sign-extended from bit 9. Any other destination gives `lui rd, imm`. The lui immediate has bit 12 at result bit 17 and bits 6:2 at result bits 16:12, sign-extended from bit 17.
- R5: Quadrant 2 expands funct3 000 to `slli rd, rd, shamt` with the shift amount from bits 6:2. Funct3 010 gives `lw rd, uimm(x2)` and funct3 110 gives `sw rs2, uimm(x2)`, each with a zero-extended word offset.
- R6: In quadrant 2 with funct3 100, the result depends on bit 12 and the register fields:
  - Bit 12 = 0 with bits 6:2 zero gives `jalr x0, 0(rs1)`.
  - Bit 12 = 0 otherwise gives `add rd, x0, rs2`.
  - Bit 12 = 1 with bits 11:2 zero gives ebreak (0x00100073).
  - Bit 12 = 1 with only bits 6:2 zero gives `jalr x1, 0(rs1)`.
  - Bit 12 = 1 otherwise gives `add rd, rd, rs2`.
- R7: The illegal flag is set, and the output word is zero, for each of these inputs:
  - the all-zero halfword;
  - the quadrant-0 add with a zero offset;
  - the stack adjust with a zero immediate;
  - lui with rd = 0 or a zero immediate;
  - srli, srai or slli with bit 12 set;
  - the register-register group with bit 12 set;
  - the floating-point or unused funct3 slots (quadrant 0: 001, 011, 100, 101, 111; quadrant 2: 001, 011, 101, 111).
- R8: The compressed flag is 1 for quadrants 0 to 2. Quadrant 3 (bits 1:0 = 11) gives compressed flag 0, illegal 1 and a zero word.
- R9: With the output register present, the outputs for a strobed input appear one clock later, and out_valid follows in_valid with one cycle of delay.
- R10: A cycle with in_valid low drives out_valid low after the next clock and leaves out_instr, out_illegal and out_is_compressed unchanged.
- R11: During reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: in_instr holds a halfword to expand |
| in_instr | input | 16 | Compressed instruction |
| out_valid | output | 1 | Result of a strobed input is present |
| out_instr | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal | output | 1 | Encoding is reserved, illegal or outside the subset |
| out_is_compressed | output | 1 | Source was 16 bits wide (link and next PC step by 2) |

## Verification
A wrong sub-decode or a mis-scrambled immediate shows up in out_instr one clock after the strobe. It appears as a different opcode, funct or register field, or as shifted offset bits. The fault is limited to the encodings that use that path, which is why every sub-decode corner and every immediate layout is driven with random fields. A stale or wrongly enabled output register shows up in the idle cycle that follows, as a word that changes or a valid flag that stays high. A missed reserved case shows up as a nonzero word with the illegal flag low.

// File: rtl/rvc_exp_pkg.sv
package rvc_exp_pkg;

   localparam int unsigned C_W = 16;
   localparam int unsigned I_W = 32;
   localparam int unsigned R_W = 5;

   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_OP_IMM = 7'b0010011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;

   localparam logic [I_W-1:0] WORD_EBREAK = 32'h0010_0073;

   localparam logic [4:0] REG_ZERO = 5'd0;
   localparam logic [4:0] REG_RA   = 5'd1;
   localparam logic [4:0] REG_SP   = 5'd2;

   typedef struct packed {
      logic [I_W-1:0] word;
      logic           bad;
   } rvc_exp_t;

   function automatic logic [I_W-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                            input logic [2:0] f3, input logic [4:0] rd,
                                            input logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction

   function automatic logic [I_W-1:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3,
                                            input logic [4:0] rd, input logic [6:0] op);
      return {f7, rs2, rs1, f3, rd, op};
   endfunction

   function automatic logic [I_W-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3);
      return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
   endfunction

   function automatic logic [I_W-1:0] enc_b(input logic [12:0] imm, input logic [4:0] rs1,
                                            input logic [2:0] f3);
      return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
   endfunction

   function automatic logic [I_W-1:0] enc_u(input logic [19:0] imm, input logic [4:0] rd);
      return {imm, rd, OPC_LUI};
   endfunction

   function automatic logic [I_W-1:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
      return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
   endfunction

   // 3-bit register field -> x8..x15
   function automatic logic [4:0] short_reg(input logic [2:0] f);
      return {2'b01, f};
   endfunction

endpackage

// File: rtl/rvc_q0_dec.sv
module rvc_q0_dec
   import rvc_exp_pkg::*;
(
   input  logic [15:2] c,
   output rvc_exp_t    r
);

   logic [11:0] spn_off;
   logic [11:0] mem_off;
   logic [4:0]  rd_s;
   logic [4:0]  rs1_s;

   assign spn_off = {2'b00, c[10:7], c[12:11], c[5], c[6], 2'b00};
   assign mem_off = {5'b00000, c[5], c[12:10], c[6], 2'b00};
   assign rd_s    = short_reg(c[4:2]);
   assign rs1_s   = short_reg(c[9:7]);

   always_comb begin
      r.word = '0;
      r.bad  = 1'b0;
      unique case (c[15:13])
         3'b000: begin
            r.word = enc_i(spn_off, REG_SP, 3'b000, rd_s, OPC_OP_IMM);
            r.bad  = (spn_off == 12'd0);
         end
         3'b010: r.word = enc_i(mem_off, rs1_s, 3'b010, rd_s, OPC_LOAD);
         3'b110: r.word = enc_s(mem_off, rd_s, rs1_s, 3'b010);
         default: r.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/rvc_q1_dec.sv
module rvc_q1_dec
   import rvc_exp_pkg::*;
(
   input  logic [15:2] c,
   output rvc_exp_t    r
);

   logic [4:0]  rd_f;
   logic [4:0]  rs1_s;
   logic [4:0]  rs2_s;
   logic [11:0] imm6;
   logic [20:0] jmp_off;
   logic [12:0] br_off;
   logic [11:0] sp_imm;
   logic [19:0] up_imm;
   logic [11:0] sh_lo;
   logic [11:0] sh_ar;
   logic [6:0]  rr_f7;
   logic [2:0]  rr_f3;

   assign rd_f    = c[11:7];
   assign rs1_s   = short_reg(c[9:7]);
   assign rs2_s   = short_reg(c[4:2]);
   assign imm6    = {{6{c[12]}}, c[12], c[6:2]};
   assign jmp_off = {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
   assign br_off  = {{4{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
   assign sp_imm  = {{2{c[12]}}, c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
   assign up_imm  = {{14{c[12]}}, c[12], c[6:2]};
   assign sh_lo   = {7'b0000000, c[6:2]};
   assign sh_ar   = {7'b0100000, c[6:2]};

   // register-register group selected by bits 6:5
   always_comb begin
      rr_f7 = 7'b0000000;
      unique case (c[6:5])
         2'b00: begin rr_f7 = 7'b0100000; rr_f3 = 3'b000; end
         2'b01: rr_f3 = 3'b100;
         2'b10: rr_f3 = 3'b110;
         default: rr_f3 = 3'b111;
      endcase
   end

   always_comb begin
      r.word = '0;
      r.bad  = 1'b0;
      unique case (c[15:13])
         3'b000: r.word = enc_i(imm6, rd_f, 3'b000, rd_f, OPC_OP_IMM);
         3'b001: r.word = enc_j(jmp_off, REG_RA);
         3'b010: r.word = enc_i(imm6, REG_ZERO, 3'b000, rd_f, OPC_OP_IMM);
         3'b011: begin
            if (rd_f == REG_SP) begin
               r.word = enc_i(sp_imm, REG_SP, 3'b000, REG_SP, OPC_OP_IMM);
               r.bad  = (sp_imm == 12'd0);
            end else begin
               r.word = enc_u(up_imm, rd_f);
               r.bad  = (rd_f == REG_ZERO) || ({c[12], c[6:2]} == 6'd0);
            end
         end
         3'b100: begin
            unique case (c[11:10])
               2'b00: begin
                  r.word = enc_i(sh_lo, rs1_s, 3'b101, rs1_s, OPC_OP_IMM);
                  r.bad  = c[12];
               end
               2'b01: begin
                  r.word = enc_i(sh_ar, rs1_s, 3'b101, rs1_s, OPC_OP_IMM);
                  r.bad  = c[12];
               end
               2'b10: r.word = enc_i(imm6, rs1_s, 3'b111, rs1_s, OPC_OP_IMM);
               default: begin
                  r.word = enc_r(rr_f7, rs2_s, rs1_s, rr_f3, rs1_s, OPC_OP);
                  r.bad  = c[12];
               end
            endcase
         end
         3'b101: r.word = enc_j(jmp_off, REG_ZERO);
         3'b110: r.word = enc_b(br_off, rs1_s, 3'b000);
         default: r.word = enc_b(br_off, rs1_s, 3'b001);
      endcase
   end

endmodule

// File: rtl/rvc_q2_dec.sv
module rvc_q2_dec
   import rvc_exp_pkg::*;
(
   input  logic [15:2] c,
   output rvc_exp_t    r
);

   logic [4:0]  rd_f;
   logic [4:0]  rs2_f;
   logic [11:0] ld_off;
   logic [11:0] st_off;
   logic [11:0] shamt;
   logic        rs2_zero;
   logic        body_zero;

   assign rd_f      = c[11:7];
   assign rs2_f     = c[6:2];
   assign ld_off    = {4'b0000, c[3:2], c[12], c[6:4], 2'b00};
   assign st_off    = {4'b0000, c[8:7], c[12:9], 2'b00};
   assign shamt     = {7'b0000000, c[6:2]};
   assign rs2_zero  = (rs2_f == 5'd0);
   assign body_zero = rs2_zero && (rd_f == 5'd0);

   always_comb begin
      r.word = '0;
      r.bad  = 1'b0;
      unique case (c[15:13])
         3'b000: begin
            r.word = enc_i(shamt, rd_f, 3'b001, rd_f, OPC_OP_IMM);
            r.bad  = c[12];
         end
         3'b010: r.word = enc_i(ld_off, REG_SP, 3'b010, rd_f, OPC_LOAD);
         3'b110: r.word = enc_s(st_off, rs2_f, REG_SP, 3'b010);
         3'b100: begin
            if (!c[12]) begin
               if (rs2_zero) r.word = enc_i(12'd0, rd_f, 3'b000, REG_ZERO, OPC_JALR);
               else          r.word = enc_r(7'd0, rs2_f, REG_ZERO, 3'b000, rd_f, OPC_OP);
            end else begin
               if (body_zero)     r.word = WORD_EBREAK;
               else if (rs2_zero) r.word = enc_i(12'd0, rd_f, 3'b000, REG_RA, OPC_JALR);
               else               r.word = enc_r(7'd0, rs2_f, rd_f, 3'b000, rd_f, OPC_OP);
            end
         end
         default: r.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
   import rvc_exp_pkg::*;
#(
   parameter int unsigned REG_OUT = 1
)
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [C_W-1:0] in_instr,
   output logic           out_valid,
   output logic [I_W-1:0] out_instr,
   output logic           out_illegal,
   output logic           out_is_compressed
);

   localparam logic [1:0] QUAD_WIDE = 2'b11;

   if (REG_OUT > 1) begin : g_bad_reg_out
      $error("rvc_expander: REG_OUT must be 0 or 1");
   end
   if (C_W != 16 || I_W != 32) begin : g_bad_width
      $error("rvc_expander: only 16->32 expansion is supported");
   end

   rvc_exp_t   q_res [3];
   rvc_exp_t   sel;
   logic       nxt_comp;
   logic [I_W-1:0] nxt_word;

   rvc_q0_dec u_q0 (.c(in_instr[15:2]), .r(q_res[0]));
   rvc_q1_dec u_q1 (.c(in_instr[15:2]), .r(q_res[1]));
   rvc_q2_dec u_q2 (.c(in_instr[15:2]), .r(q_res[2]));

   always_comb begin
      unique case (in_instr[1:0])
         2'b00:   sel = q_res[0];
         2'b01:   sel = q_res[1];
         2'b10:   sel = q_res[2];
         default: begin
            sel.word = '0;
            sel.bad  = 1'b1;
         end
      endcase
   end

   assign nxt_comp = (in_instr[1:0] != QUAD_WIDE);
   assign nxt_word = sel.bad ? '0 : sel.word;

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid         <= 1'b0;
            out_instr         <= '0;
            out_illegal       <= 1'b0;
            out_is_compressed <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_instr         <= nxt_word;
               out_illegal       <= sel.bad;
               out_is_compressed <= nxt_comp;
            end
         end
      end
   end else begin : g_comb
      assign out_valid         = in_valid;
      assign out_instr         = nxt_word;
      assign out_illegal       = sel.bad;
      assign out_is_compressed = nxt_comp;
   end

endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk #(
   parameter int unsigned REG_OUT = 1
)
(
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [15:0] in_instr,
   input logic        out_valid,
   input logic [31:0] out_instr,
   input logic        out_illegal,
   input logic        out_is_compressed
);

   AST_ILLEGAL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (out_instr == 32'd0)); // R7

   AST_LEGAL_WIDE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal) |-> (out_instr[1:0] == 2'b11)); // R1

   AST_NARROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_is_compressed) |-> out_illegal); // R8

   if (REG_OUT == 1) begin : g_seq
      AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R9

      AST_IDLE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid); // R10

      AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_instr) && $stable(out_illegal))); // R10

      AST_ZERO_HALF_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_instr == 16'h0000) |=> out_illegal); // R7

      AST_WIDE_QUAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_instr[1:0] == 2'b11) |=> (out_illegal && !out_is_compressed)); // R8

      AST_EBREAK_MAP: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_instr == 16'h9002) |=> (out_instr == 32'h0010_0073)); // R6
   end

endmodule

bind rvc_expander rvc_expander_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
   .out_valid(out_valid), .out_instr(out_instr), .out_illegal(out_illegal),
   .out_is_compressed(out_is_compressed)
);

// File: tb/rvc_expander_tb_top.sv
module rvc_expander_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] OP_IMM = 7'b0010011;
   localparam logic [6:0] OP_REG = 7'b0110011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_instr = 16'h0;
   logic        out_valid;
   logic [31:0] out_instr;
   logic        out_illegal;
   logic        out_is_compressed;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] last_exp = 32'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rvc_expander dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .out_valid(out_valid), .out_instr(out_instr), .out_illegal(out_illegal),
      .out_is_compressed(out_is_compressed)
   );

   // ---------------- reference 32-bit encoders ----------------
   function automatic logic [31:0] w_i(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3,
                                       logic [4:0] rd, logic [6:0] op);
      return {im, rs1, f3, rd, op};
   endfunction
   function automatic logic [31:0] w_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd);
      return {f7, rs2, rs1, f3, rd, OP_REG};
   endfunction
   function automatic logic [31:0] w_s(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1);
      return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] w_b(logic [12:0] im, logic [4:0] rs1, logic [2:0] f3);
      return {im[12], im[10:5], 5'd0, rs1, f3, im[4:1], im[11], 7'b1100011};
   endfunction
   function automatic logic [31:0] w_j(logic [20:0] im, logic [4:0] rd);
      return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
   endfunction

   // ---------------- compressed builders ----------------
   function automatic logic [15:0] h_spn(logic [7:0] u, logic [2:0] rp);
      return {3'b000, u[3:2], u[7:4], u[0], u[1], rp, 2'b00};
   endfunction
   function automatic logic [15:0] h_mem(logic [2:0] f3, logic [4:0] u, logic [2:0] bp, logic [2:0] rp);
      return {f3, u[3:1], bp, u[0], u[4], rp, 2'b00};
   endfunction
   function automatic logic [15:0] h_ci(logic [2:0] f3, logic [5:0] im, logic [4:0] rd, logic [1:0] q);
      return {f3, im[5], rd, im[4:0], q};
   endfunction
   function automatic logic [15:0] h_jmp(logic [2:0] f3, logic [11:0] o);
      return {f3, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
   endfunction
   function automatic logic [15:0] h_br(logic [2:0] f3, logic [8:0] o, logic [2:0] bp);
      return {f3, o[8], o[4:3], bp, o[7:6], o[2:1], o[5], 2'b01};
   endfunction
   function automatic logic [15:0] h_sp16(logic [9:0] i);
      return {3'b011, i[9], 5'd2, i[4], i[6], i[8:7], i[5], 2'b01};
   endfunction
   function automatic logic [15:0] h_sh(logic b12, logic [1:0] f2, logic [2:0] rp, logic [4:0] lo);
      return {3'b100, b12, f2, rp, lo, 2'b01};
   endfunction
   function automatic logic [15:0] h_rr(logic [1:0] f2, logic [2:0] rp, logic [2:0] sp);
      return {3'b100, 1'b0, 2'b11, rp, f2, sp, 2'b01};
   endfunction
   function automatic logic [15:0] h_lwsp(logic [4:0] rd, logic [5:0] u);
      return {3'b010, u[3], rd, u[2:0], u[5:4], 2'b10};
   endfunction
   function automatic logic [15:0] h_swsp(logic [4:0] rs2, logic [5:0] u);
      return {3'b110, u[3:0], u[5:4], rs2, 2'b10};
   endfunction
   function automatic logic [15:0] h_cr(logic b12, logic [4:0] rd, logic [4:0] rs2);
      return {3'b100, b12, rd, rs2, 2'b10};
   endfunction

   // ---------------- checking ----------------
   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h (time %0t)", rq, act, exp, $time);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge (one register)
   task automatic step(input logic [15:0] c, input logic [31:0] e, input logic bad,
                       input logic comp, input string rq);
      in_valid = 1'b1;
      in_instr = c;
      @(negedge clk);
      chk({rq, " R9 valid"}, {31'd0, out_valid}, 32'd1);
      chk({rq, " word"}, out_instr, bad ? 32'd0 : e);
      chk({rq, " illegal"}, {31'd0, out_illegal}, {31'd0, bad});
      chk({rq, " R8 compressed"}, {31'd0, out_is_compressed}, {31'd0, comp});
      last_exp = bad ? 32'd0 : e;
   endtask

   task automatic idle(input logic [15:0] c);
      in_valid = 1'b0;
      in_instr = c;
      @(negedge clk);
      chk("R10 valid low", {31'd0, out_valid}, 32'd0);
      chk("R10 word held", out_instr, last_exp);
   endtask

   logic [31:0] rnd;
   logic [15:0] hc;
   logic [31:0] ew;
   logic [4:0]  rd5, rs5;
   logic [2:0]  ra, rb;
   logic [5:0]  i6;
   string       tag;

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 valid", {31'd0, out_valid}, 32'd0);
      chk("R11 word", out_instr, 32'd0);
      chk("R11 illegal", {31'd0, out_illegal}, 32'd0);
      chk("R11 compressed", {31'd0, out_is_compressed}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 440; i++) begin
         rnd = $urandom();
         rd5 = rnd[4:0];
         rs5 = rnd[9:5];
         ra  = rnd[12:10];
         rb  = rnd[15:13];
         i6  = rnd[21:16];
         case (i % 22)
            0: begin // R1 stack-relative add
               logic [7:0] u = (rnd[31:24] == 8'd0) ? 8'd1 : rnd[31:24];
               hc = h_spn(u, ra); ew = w_i({2'b00, u, 2'b00}, 5'd2, 3'b000, {2'b01, ra}, OP_IMM);
               tag = "R1 addi4spn";
            end
            1: begin hc = h_mem(3'b010, rnd[26:22], rb, ra);
               ew = w_i({5'd0, rnd[26:22], 2'b00}, {2'b01, rb}, 3'b010, {2'b01, ra}, 7'b0000011);
               tag = "R1 lw"; end
            2: begin hc = h_mem(3'b110, rnd[26:22], rb, ra);
               ew = w_s({5'd0, rnd[26:22], 2'b00}, {2'b01, ra}, {2'b01, rb});
               tag = "R1 sw"; end
            3: begin hc = h_ci(3'b000, i6, rd5, 2'b01);
               ew = w_i({{6{i6[5]}}, i6}, rd5, 3'b000, rd5, OP_IMM); tag = "R2 addi"; end
            4: begin hc = h_ci(3'b010, i6, rd5, 2'b01);
               ew = w_i({{6{i6[5]}}, i6}, 5'd0, 3'b000, rd5, OP_IMM); tag = "R2 li"; end
            5: begin hc = h_jmp(3'b001, {rnd[31:21], 1'b0});
               ew = w_j({{9{rnd[31]}}, rnd[31:21], 1'b0}, 5'd1); tag = "R2 jal"; end
            6: begin hc = h_jmp(3'b101, {rnd[31:21], 1'b0});
               ew = w_j({{9{rnd[31]}}, rnd[31:21], 1'b0}, 5'd0); tag = "R2 j"; end
            7: begin hc = h_br(3'b110, {rnd[31:24], 1'b0}, ra);
               ew = w_b({{4{rnd[31]}}, rnd[31:24], 1'b0}, {2'b01, ra}, 3'b000); tag = "R2 beqz"; end
            8: begin hc = h_br(3'b111, {rnd[31:24], 1'b0}, ra);
               ew = w_b({{4{rnd[31]}}, rnd[31:24], 1'b0}, {2'b01, ra}, 3'b001); tag = "R2 bnez"; end
            9: begin // R4 stack adjust
               logic [5:0] s = (i6 == 6'd0) ? 6'd1 : i6;
               hc = h_sp16({s, 4'b0000});
               ew = w_i({{2{s[5]}}, s, 4'b0000}, 5'd2, 3'b000, 5'd2, OP_IMM); tag = "R4 addi16sp";
            end
            10: begin // R4 upper immediate
               logic [5:0] s = (i6 == 6'd0) ? 6'd33 : i6;
               logic [4:0] d = (rd5 == 5'd0 || rd5 == 5'd2) ? 5'd9 : rd5;
               hc = h_ci(3'b011, s, d, 2'b01);
               ew = {{14{s[5]}}, s, d, 7'b0110111}; tag = "R4 lui";
            end
            11: begin hc = h_sh(1'b0, 2'b00, ra, rs5);
               ew = w_i({7'd0, rs5}, {2'b01, ra}, 3'b101, {2'b01, ra}, OP_IMM); tag = "R3 srli"; end
            12: begin hc = h_sh(1'b0, 2'b01, ra, rs5);
               ew = w_i({7'b0100000, rs5}, {2'b01, ra}, 3'b101, {2'b01, ra}, OP_IMM); tag = "R3 srai"; end
            13: begin hc = h_sh(i6[5], 2'b10, ra, i6[4:0]);
               ew = w_i({{6{i6[5]}}, i6}, {2'b01, ra}, 3'b111, {2'b01, ra}, OP_IMM); tag = "R3 andi"; end
            14: begin
               logic [1:0] f2 = rnd[23:22];
               logic [6:0] f7 = (f2 == 2'b00) ? 7'b0100000 : 7'd0;
               logic [2:0] f3 = (f2 == 2'b00) ? 3'b000 : (f2 == 2'b01) ? 3'b100 :
                                (f2 == 2'b10) ? 3'b110 : 3'b111;
               hc = h_rr(f2, ra, rb);
               ew = w_r(f7, {2'b01, rb}, {2'b01, ra}, f3, {2'b01, ra}); tag = "R3 sub/xor/or/and";
            end
            15: begin hc = h_ci(3'b000, {1'b0, rs5}, rd5, 2'b10);
               ew = w_i({7'd0, rs5}, rd5, 3'b001, rd5, OP_IMM); tag = "R5 slli"; end
            16: begin hc = h_lwsp(rd5, i6);
               ew = w_i({4'd0, i6, 2'b00}, 5'd2, 3'b010, rd5, 7'b0000011); tag = "R5 lwsp"; end
            17: begin hc = h_swsp(rs5, i6);
               ew = w_s({4'd0, i6, 2'b00}, rs5, 5'd2); tag = "R5 swsp"; end
            18: begin
               logic [4:0] s = (rs5 == 5'd0) ? 5'd7 : rs5;
               hc = h_cr(1'b0, rd5, s); ew = w_r(7'd0, s, 5'd0, 3'b000, rd5); tag = "R6 mv";
            end
            19: begin
               logic [4:0] s = (rs5 == 5'd0) ? 5'd3 : rs5;
               hc = h_cr(1'b1, rd5, s); ew = w_r(7'd0, s, rd5, 3'b000, rd5); tag = "R6 add";
            end
            20: begin hc = h_cr(1'b0, rd5, 5'd0);
               ew = w_i(12'd0, rd5, 3'b000, 5'd0, 7'b1100111); tag = "R6 jr"; end
            default: begin
               logic [4:0] s = (rd5 == 5'd0) ? 5'd1 : rd5;
               hc = h_cr(1'b1, s, 5'd0);
               ew = w_i(12'd0, s, 3'b000, 5'd1, 7'b1100111); tag = "R6 jalr";
            end
         endcase
         step(hc, ew, 1'b0, 1'b1, tag);
         if (i % 11 == 0) idle(~hc);
      end

      // directed corners
      step(16'h9002, 32'h0010_0073, 1'b0, 1'b1, "R6 ebreak");
      idle(16'h0000);
      step(16'h0000, 32'd0, 1'b1, 1'b1, "R7 zero halfword");
      step(h_spn(8'd0, 3'd3), 32'd0, 1'b1, 1'b1, "R7 addi4spn zero");
      step(h_sp16(10'd0), 32'd0, 1'b1, 1'b1, "R7 addi16sp zero");
      step(h_ci(3'b011, 6'd1, 5'd0, 2'b01), 32'd0, 1'b1, 1'b1, "R7 lui rd0");
      step(h_ci(3'b011, 6'd0, 5'd5, 2'b01), 32'd0, 1'b1, 1'b1, "R7 lui zero imm");
      step(h_sh(1'b1, 2'b00, 3'd1, 5'd3), 32'd0, 1'b1, 1'b1, "R7 srli bit12");
      step(h_sh(1'b1, 2'b01, 3'd1, 5'd3), 32'd0, 1'b1, 1'b1, "R7 srai bit12");
      step(h_ci(3'b000, 6'h21, 5'd5, 2'b10), 32'd0, 1'b1, 1'b1, "R7 slli bit12");
      step({3'b100, 1'b1, 2'b11, 3'd1, 2'b00, 3'd2, 2'b01}, 32'd0, 1'b1, 1'b1, "R7 rr bit12");
      step(16'h2000, 32'd0, 1'b1, 1'b1, "R7 q0 unused slot");
      step(16'h6002, 32'd0, 1'b1, 1'b1, "R7 q2 unused slot");
      idle(16'h1234);
      step(16'h0003, 32'd0, 1'b1, 1'b0, "R8 quadrant 3");
      step(h_ci(3'b011, 6'h20, 5'd7, 2'b01), 32'hFFFE_03B7, 1'b0, 1'b1, "R4 lui negative");
      step(h_sp16(10'h200), w_i(12'hE00, 5'd2, 3'b000, 5'd2, OP_IMM), 1'b0, 1'b1, "R4 addi16sp -512");
      idle(16'hFFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule